// File: doc/BRIEF.md
# EEPROM Write-Protection Gate

This block stands between the raw host strobes of a parallel EEPROM and its page-write loader. It decides, every clock cycle, whether a write attempt by the host may go on to the loader. A write is refused while the supply-good comparator reports a low supply, and for a fixed number of cycles after the supply becomes good. It is also refused while any of the level inhibits holds (output enable asserted, chip enable released, write enable released), and when the strobe is too short to pass the glitch filter. All strobe inputs are active low and are assumed to be synchronized to `clk` already.

A software protection state machine watches the qualified writes for a fixed three-write command sequence. Each write in the sequence is a pair of address and data values, and all six values are parameters. Once the sequence completes, protection turns on and stays on until reset. While it is on, no write reaches the loader. Protection is off after reset.

The output `wr_go` is a one-cycle pulse for each accepted write. The loader samples the host address and data in that cycle. `prot_on` reports the protection state.

Top module: `eeprom_wr_guard`

## Requirements
- R1: While `supply_ok` is low, `wr_go` stays low. `wr_go` is also low during reset.
- R2: When `supply_ok` rises, the PWR_DLY count starts. A strobe that begins d clock cycles after the rise passes only if d + FILT_W - 1 >= PWR_DLY, which means the gate counts PWR_DLY consecutive good cycles before the strobe's FILT_W-th sample.
- R3: Each of these conditions blocks a write: `oe_n` low, `cs_n` high, or `we_n` high.
- R4: A strobe is the state `cs_n`=0, `we_n`=0, `oe_n`=1. It is accepted only if it holds for FILT_W consecutive clock samples. A shorter strobe produces no pulse.
- R5: An accepted strobe produces exactly one `wr_go` pulse, one cycle wide, however long the strobe is held. The pulse starts at the FILT_W-th rising edge after the strobe begins.
- R6: `prot_on` is 0 after reset.
- R7: Three accepted writes in a row, (CMD0_ADDR, CMD0_DATA), (CMD1_ADDR, CMD1_DATA), (CMD2_ADDR, CMD2_DATA), set `prot_on` to 1, and it stays 1 until reset. The defaults are 0x1555/0xAA, 0x0AAA/0x55 and 0x1555/0xA0.
- R8: An accepted write whose address or data does not match the expected step sends the recognizer back to idle. It does not restart at step one, even if the write matches the first command.
- R9: While `prot_on` is 1, no `wr_go` pulse is produced, including for the command writes. While it is 0, every accepted write pulses `wr_go`, including all three command writes.
- R10: A strobe that is filtered out, inhibited or locked out does not advance or reset the recognizer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| supply_ok | input | 1 | Supply at or above the 3.8 V threshold (comparator output) |
| cs_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | AW | Host address |
| wdata | input | DW | Host write data |
| wr_go | output | 1 | Qualified write strobe, one-cycle pulse |
| prot_on | output | 1 | Software protection enabled |

## Verification
The bench builds the gate with FILT_W=3 and PWR_DLY=20 and keeps the default command values. The short filter lets a sweep of strobe widths from 1 to 6 cover both sides of the acceptance edge. The short power-up count lets every strobe start offset around the lockout boundary be tried with arithmetic expectations. Because each reset costs only a few dozen cycles, the bench can reset before every command-sequence case. It then corrupts each step's address or data in turn and checks both that the sequence fails to arm and that a later clean sequence still arms.

// File: rtl/eeprom_wr_guard_pkg.sv
// Shared types for the EEPROM write-protection gate.
package eeprom_wr_guard_pkg;
    // Progress of the protection command recognizer.
    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_GOT1 = 2'd1,
        SEQ_GOT2 = 2'd2
    } seq_t;
endpackage

// File: rtl/wr_pwr_lockout.sv
// Power-up lockout: ready goes high only after supply_ok has been high for
// PWR_DLY consecutive clock cycles, and it drops at once when supply_ok falls.
// Assumes supply_ok is already synchronous to clk and PWR_DLY >= 1.
module wr_pwr_lockout #(
    parameter int PWR_DLY = 625000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok,
    output logic ready
);
    localparam int PW = $clog2(PWR_DLY + 1);
    localparam logic [PW-1:0] DLY_V = PW'(PWR_DLY);

    logic [PW-1:0] pcnt;

    // Count good-supply cycles, saturating at the delay; clear on a low supply.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pcnt <= '0;
        else if (!supply_ok)
            pcnt <= '0;
        else if (pcnt != DLY_V)
            pcnt <= pcnt + 1'b1;
    end

    assign ready = supply_ok && (pcnt == DLY_V);

    // R2: ready implies the supply was good at the previous edge as well
    a_r2_ready_after_good: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (supply_ok && $past(supply_ok)));
endmodule

// File: rtl/wr_glitch_filter.sv
// Minimum-width filter for the combined write strobe: it raises evt for one
// cycle once act has been sampled high for FILT_W consecutive cycles, and then
// stays quiet until act drops. Assumes act is synchronous to clk and FILT_W >= 1.
module wr_glitch_filter #(
    parameter int FILT_W = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic act,
    output logic evt
);
    localparam int FW = $clog2(FILT_W + 1);
    localparam logic [FW-1:0] FW_V = FW'(FILT_W);

    logic [FW-1:0] cnt;

    // Count consecutive active samples, saturating at the filter width.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (!act)
            cnt <= '0;
        else if (cnt != FW_V)
            cnt <= cnt + 1'b1;
    end

    assign evt = act && (cnt == FW_V - 1'b1);

    // R5: one event per strobe, never two cycles in a row
    a_r5_single_evt: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> !evt);
    // R4: an event only while the strobe is active
    a_r4_evt_needs_act: assert property (@(posedge clk) disable iff (!rst_n)
        evt |-> act);
endmodule

// File: rtl/wr_cmd_seq.sv
// Recognizer for the three-write protection command. Each accepted write
// (take) either advances one step or returns to idle. A match on the last
// step turns protection on until reset.
module wr_cmd_seq
    import eeprom_wr_guard_pkg::*;
#(
    parameter int AW = 13,
    parameter int DW = 8,
    parameter logic [AW-1:0] CMD0_ADDR = 13'h1555,
    parameter logic [DW-1:0] CMD0_DATA = 8'hAA,
    parameter logic [AW-1:0] CMD1_ADDR = 13'h0AAA,
    parameter logic [DW-1:0] CMD1_DATA = 8'h55,
    parameter logic [AW-1:0] CMD2_ADDR = 13'h1555,
    parameter logic [DW-1:0] CMD2_DATA = 8'hA0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          take,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic          prot_on
);
    seq_t st;
    logic prot_q;
    logic hit;

    // Compare the current write with the command expected at this step.
    always_comb begin
        case (st)
            SEQ_IDLE: hit = (addr == CMD0_ADDR) && (wdata == CMD0_DATA);
            SEQ_GOT1: hit = (addr == CMD1_ADDR) && (wdata == CMD1_DATA);
            SEQ_GOT2: hit = (addr == CMD2_ADDR) && (wdata == CMD2_DATA);
            default:  hit = 1'b0;
        endcase
    end

    // Advance on a match, fall back to idle on a mismatch, arm on the last step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= SEQ_IDLE;
            prot_q <= 1'b0;
        end else if (take) begin
            case (st)
                SEQ_IDLE: st <= hit ? SEQ_GOT1 : SEQ_IDLE;
                SEQ_GOT1: st <= hit ? SEQ_GOT2 : SEQ_IDLE;
                default: begin
                    st <= SEQ_IDLE;
                    if (hit) prot_q <= 1'b1;
                end
            endcase
        end
    end

    assign prot_on = prot_q;

    // R7: protection stays on until reset
    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        prot_on |=> prot_on);
    // R7: protection turns on only from an accepted write at the last step
    a_r7_arm_from_last: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prot_on) |-> ($past(take) && $past(st) == SEQ_GOT2));
    // R10: state moves only on an accepted write
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> $stable(st));
endmodule

// File: rtl/eeprom_wr_guard.sv
// EEPROM write-protection gate. A write reaches the loader (wr_go pulse)
// only when the supply is good and settled, the strobe levels allow a write,
// the strobe survives the glitch filter, and software protection is off.
// Assumes all inputs are synchronous to clk.
module eeprom_wr_guard #(
    parameter int AW      = 13,
    parameter int DW      = 8,
    parameter int FILT_W  = 2,
    parameter int PWR_DLY = 625000,
    parameter logic [AW-1:0] CMD0_ADDR = 13'h1555,
    parameter logic [DW-1:0] CMD0_DATA = 8'hAA,
    parameter logic [AW-1:0] CMD1_ADDR = 13'h0AAA,
    parameter logic [DW-1:0] CMD1_DATA = 8'h55,
    parameter logic [AW-1:0] CMD2_ADDR = 13'h1555,
    parameter logic [DW-1:0] CMD2_DATA = 8'hA0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          supply_ok,
    input  logic          cs_n,
    input  logic          we_n,
    input  logic          oe_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic          wr_go,
    output logic          prot_on
);
    logic ready;
    logic act;
    logic evt;
    logic take;
    logic go_q;

    assign act  = !cs_n && !we_n && oe_n;
    assign take = evt && ready;

    wr_pwr_lockout #(.PWR_DLY(PWR_DLY)) i_lockout (
        .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .ready(ready)
    );

    wr_glitch_filter #(.FILT_W(FILT_W)) i_filter (
        .clk(clk), .rst_n(rst_n), .act(act), .evt(evt)
    );

    wr_cmd_seq #(
        .AW(AW), .DW(DW),
        .CMD0_ADDR(CMD0_ADDR), .CMD0_DATA(CMD0_DATA),
        .CMD1_ADDR(CMD1_ADDR), .CMD1_DATA(CMD1_DATA),
        .CMD2_ADDR(CMD2_ADDR), .CMD2_DATA(CMD2_DATA)
    ) i_seq (
        .clk(clk), .rst_n(rst_n), .take(take),
        .addr(addr), .wdata(wdata), .prot_on(prot_on)
    );

    // Register the qualified strobe; protection state is taken before any update.
    always_ff @(posedge clk) begin
        if (!rst_n)
            go_q <= 1'b0;
        else
            go_q <= take && !prot_on;
    end

    assign wr_go = go_q;

    // R1: a low supply blocks the next strobe
    a_r1_supply_block: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> !wr_go);
    // R3: a pulse needs the write levels in the cycle before
    a_r3_levels: assert property (@(posedge clk) disable iff (!rst_n)
        wr_go |-> $past(oe_n && !cs_n && !we_n));
    // R9: protection blocks every later write
    a_r9_protected: assert property (@(posedge clk) disable iff (!rst_n)
        prot_on |=> !wr_go);
endmodule

// File: tb/test_eeprom_wr_guard.sv
`timescale 1ns/1ps
module test_eeprom_wr_guard;
    localparam int AW = 13;
    localparam int DW = 8;
    localparam int FW = 3;
    localparam int PD = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic supply_ok = 1'b1;
    logic cs_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic wr_go, prot_on;

    int n_run = 0, n_fail = 0, pulses = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    eeprom_wr_guard #(.AW(AW), .DW(DW), .FILT_W(FW), .PWR_DLY(PD)) i_eeprom_wr_guard (
        .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .cs_n(cs_n), .we_n(we_n),
        .oe_n(oe_n), .addr(addr), .wdata(wdata), .wr_go(wr_go), .prot_on(prot_on)
    );

    // Count wr_go high cycles, sampled away from the active edge.
    always @(negedge clk) if (rst_n && wr_go) pulses++;

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Reset, then wait until the lockout has expired.
    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; supply_ok = 1'b1; cs_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
        idle(3);
        rst_n = 1'b1;
        idle(PD + 2);
    endtask

    // Drive one strobe for w cycles and return the number of wr_go cycles seen.
    task automatic strobe(input int w, input logic [AW-1:0] a, input logic [DW-1:0] d,
                          input logic cs_v, input logic we_v, input logic oe_v,
                          output int got);
        int base;
        base = pulses;
        addr = a; wdata = d; cs_n = cs_v; we_n = we_v; oe_n = oe_v;
        idle(w);
        cs_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
        idle(3);
        got = pulses - base;
    endtask

    task automatic wr(input int w, input logic [AW-1:0] a, input logic [DW-1:0] d,
                      output int got);
        strobe(w, a, d, 1'b0, 1'b0, 1'b1, got);
    endtask

    initial begin
        int got;
        int tot;
        @(negedge clk); @(negedge clk);
        chk("R1 wr_go in reset", int'(wr_go), 0);
        chk("R6 prot_on in reset", int'(prot_on), 0);
        rst_n = 1'b1;
        idle(PD + 2);
        chk("R6 prot_on after reset", int'(prot_on), 0);

        // R4/R5: width sweep around the filter edge
        for (int w = 1; w <= 6; w++) begin
            wr(w, 13'h0100 + AW'(w), 8'h11, got);
            chk($sformatf("R4/R5 width %0d", w), got, (w >= FW) ? 1 : 0);
        end

        // R3: each level inhibit on its own
        strobe(5, 13'h0040, 8'h22, 1'b0, 1'b0, 1'b0, got);
        chk("R3 oe_n low", got, 0);
        strobe(5, 13'h0040, 8'h22, 1'b1, 1'b0, 1'b1, got);
        chk("R3 cs_n high", got, 0);
        strobe(5, 13'h0040, 8'h22, 1'b0, 1'b1, 1'b1, got);
        chk("R3 we_n high", got, 0);

        // R1: low supply blocks writes
        supply_ok = 1'b0;
        idle(2);
        wr(6, 13'h0200, 8'h33, got);
        chk("R1 supply low", got, 0);

        // R2: strobe offset sweep around the power-up boundary
        for (int d = PD - FW - 2; d <= PD; d++) begin
            supply_ok = 1'b0;
            idle(2);
            supply_ok = 1'b1;
            idle(d);
            wr(FW, 13'h0300, 8'h44, got);
            chk($sformatf("R2 offset %0d", d), got, (d + FW - 1 >= PD) ? 1 : 0);
        end

        // R7/R9: clean sequence; command writes pass while unprotected
        do_reset();
        tot = 0;
        wr(FW, 13'h1555, 8'hAA, got); tot += got;
        wr(FW, 13'h0AAA, 8'h55, got); tot += got;
        chk("R7 not armed before step three", int'(prot_on), 0);
        wr(FW + 2, 13'h1555, 8'hA0, got); tot += got;
        chk("R9 command writes pass unprotected", tot, 3);
        chk("R7 armed", int'(prot_on), 1);
        for (int k = 0; k < 4; k++) begin
            wr(FW + k, 13'h0010 * AW'(k), 8'h5A ^ DW'(k), got);
            chk($sformatf("R9 protected write %0d", k), got, 0);
        end
        tot = 0;
        wr(FW, 13'h1555, 8'hAA, got); tot += got;
        wr(FW, 13'h0AAA, 8'h55, got); tot += got;
        wr(FW, 13'h1555, 8'hA0, got); tot += got;
        chk("R9 command writes blocked when protected", tot, 0);
        chk("R7 still armed", int'(prot_on), 1);

        // R8: corrupt each step's address or data, then a clean sequence
        for (int s = 0; s < 3; s++) begin
            for (int kind = 0; kind < 2; kind++) begin
                logic [AW-1:0] ca [3];
                logic [DW-1:0] cd [3];
                ca = '{13'h1555, 13'h0AAA, 13'h1555};
                cd = '{8'hAA, 8'h55, 8'hA0};
                if (kind == 0) ca[s] = ca[s] ^ 13'h0001; else cd[s] = cd[s] ^ 8'h01;
                do_reset();
                for (int j = 0; j <= s; j++) wr(FW, ca[j], cd[j], got);
                for (int j = s + 1; j < 3; j++) wr(FW, ca[j], cd[j], got);
                chk($sformatf("R8 bad step %0d kind %0d", s, kind), int'(prot_on), 0);
                wr(FW, 13'h1555, 8'hAA, got);
                wr(FW, 13'h0AAA, 8'h55, got);
                wr(FW, 13'h1555, 8'hA0, got);
                chk($sformatf("R8 recovers after step %0d kind %0d", s, kind), int'(prot_on), 1);
            end
        end

        // R8: repeating the first command goes to idle, not step one
        do_reset();
        wr(FW, 13'h1555, 8'hAA, got);
        wr(FW, 13'h1555, 8'hAA, got);
        wr(FW, 13'h0AAA, 8'h55, got);
        wr(FW, 13'h1555, 8'hA0, got);
        chk("R8 repeated first command", int'(prot_on), 0);

        // R10: filtered and inhibited strobes leave the recognizer alone
        do_reset();
        wr(FW, 13'h1555, 8'hAA, got);
        wr(FW - 1, 13'h0777, 8'h00, got);
        strobe(5, 13'h0777, 8'h00, 1'b0, 1'b0, 1'b0, got);
        wr(FW, 13'h0AAA, 8'h55, got);
        wr(FW, 13'h1555, 8'hA0, got);
        chk("R10 ignored strobes keep progress", int'(prot_on), 1);

        // R10/R1: locked-out writes do not advance the recognizer
        do_reset();
        supply_ok = 1'b0;
        idle(2);
        wr(FW, 13'h1555, 8'hAA, got);
        wr(FW, 13'h0AAA, 8'h55, got);
        wr(FW, 13'h1555, 8'hA0, got);
        supply_ok = 1'b1;
        idle(PD + 2);
        chk("R10 locked-out sequence not armed", int'(prot_on), 0);
        wr(FW, 13'h0AAA, 8'h55, got);
        wr(FW, 13'h1555, 8'hA0, got);
        chk("R10 no partial progress from lockout", int'(prot_on), 0);

        // R6: reset clears protection
        wr(FW, 13'h1555, 8'hAA, got);
        wr(FW, 13'h0AAA, 8'h55, got);
        wr(FW, 13'h1555, 8'hA0, got);
        do_reset();
        chk("R6 reset clears protection", int'(prot_on), 0);
        wr(FW, 13'h0050, 8'h66, got);
        chk("R5 write after reset", got, 1);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    // Watchdog: a hung run ends as a failure.
    initial begin
        #(8 * 100000);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule